// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer

This block is one 8-bit timer channel. It is built from a programmable prescaler that divides the timer clock by a chosen ratio, and an 8-bit down counter. The counter reloads from a time-constant register. A 4-bit mode field selects one of four modes. Stopped freezes the channel. Delay mode counts prescaled timer clocks. Event mode counts active edges of an auxiliary input. Pulse-width mode counts prescaled clocks only while the auxiliary input is at its active level. The timer clock is a one-cycle enable on the system clock.

Each expiry gives a one-cycle time-out pulse and toggles an output pin. A control write can force the pin low, which makes the block usable as a waveform generator. In pulse-width mode an invert flag is raised, so the interrupt logic next to the timer can flip the edge it watches on the shared input line. The data register can be read; a read returns the counter value captured when the read strobe is seen. A parameter gives a reduced, delay-only variant in which the top mode bit is ignored.

Top module: `pscl_timer`

## Requirements
- R1: Mode codes 1 to 7 select delay mode with divide ratios 4, 10, 16, 50, 64, 100 and 200 in that order. Code 0 stops the channel. A mode write takes effect on the cycle after `ctl_wr`.
- R2: Code 8 selects event mode, and codes 9 to 15 select pulse-width mode with the same seven ratios. In the reduced variant (FULL_MODES=0), bit 3 of the mode field is ignored: code 8 acts as stop, and `irq_invert` stays 0.
- R3: A count pulse that finds the counter at 1 does not decrement it. It reloads the counter from the time-constant register and sets `timeout` high for exactly one cycle, on the cycle after that pulse.
- R4: Any other count pulse decrements the counter, so a value of 0 wraps to 255. A time constant of 0 therefore expires once every 256 count pulses, and a time constant of 1 expires on every pulse.
- R5: A data write while stopped loads both the time-constant register and the counter. A data write while running changes only the time-constant register, and the counter uses the new value at its next reload.
- R6: While stopped, the counter keeps its value and the prescaler phase is cleared, so a restart begins a full divide period.
- R7: In pulse-width mode the prescaler and counter advance only while the synchronized auxiliary input equals `aux_active_high`. At any other level, nothing counts.
- R8: In event mode the prescaler is bypassed. After a two-stage synchronizer, each transition of `aux_in` to its active level that is seen on a timer-clock cycle is one count pulse.
- R9: `tout_pin` is low after reset and toggles on every expiry in every mode. A control write with `ctl_out_clr`=1 forces it low, and this takes priority over a toggle in the same cycle.
- R10: `irq_invert` is high exactly while the active mode is a pulse-width mode. It follows the mode register one cycle later.
- R11: A cycle with `data_rd` high captures the counter value of that cycle into `data_out`. `data_out` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer clock enable, one cycle per timer clock |
| aux_in | input | 1 | Auxiliary count/gate input, asynchronous |
| aux_active_high | input | 1 | Active level of aux_in (1 = high) |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_mode | input | 4 | Mode code |
| ctl_out_clr | input | 1 | Force output pin low on control write |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | 8 | Time constant to write |
| data_rd | input | 1 | Data register read strobe |
| data_out | output | 8 | Captured counter value |
| timeout | output | 1 | One-cycle expiry pulse |
| tout_pin | output | 1 | Toggling timer output |
| irq_invert | output | 1 | Edge-invert flag for the shared interrupt line |

## Verification
A wrong prescaler phase or ratio shows up first as a `timeout` that arrives a few timer clocks early or late. The error then repeats every period, and `tout_pin` drifts out of step with it. A wrong counter value or a wrong reload source can only be seen on the next read through `data_out`, or at the next expiry, which may be up to 256 count pulses away. Because of that, the bench compares every output against a reference model on every cycle, and it reads the counter often during random traffic. A bad synchronizer depth or a bad edge detector in event mode shifts expiries by whole auxiliary edges.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int MODE_W = 4;
  localparam int SEL_W  = 3;
  localparam int PSC_W  = 8;

  typedef enum logic [1:0] {K_STOP, K_DELAY, K_EVENT, K_PULSE} kind_e;

  function automatic logic [PSC_W-1:0] div_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    div_ratio = 8'd4;
      3'd2:    div_ratio = 8'd10;
      3'd3:    div_ratio = 8'd16;
      3'd4:    div_ratio = 8'd50;
      3'd5:    div_ratio = 8'd64;
      3'd6:    div_ratio = 8'd100;
      3'd7:    div_ratio = 8'd200;
      default: div_ratio = 8'd4;
    endcase
  endfunction

  function automatic kind_e mode_kind(input logic [MODE_W-1:0] m);
    if (m[SEL_W-1:0] == '0) mode_kind = m[MODE_W-1] ? K_EVENT : K_STOP;
    else                    mode_kind = m[MODE_W-1] ? K_PULSE : K_DELAY;
  endfunction
endpackage

// File: rtl/ptmr_aux_sync.sv
module ptmr_aux_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic aux_in,
  input  logic active_high,
  output logic act,
  output logic act_edge
);
  logic [STAGES-1:0] sr;
  logic              act_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) sr[0] <= 1'b0;
          else     sr[0] <= aux_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) sr[g] <= 1'b0;
          else     sr[g] <= sr[g-1];
      end
    end
  endgenerate

  assign act      = (sr[STAGES-1] == active_high);
  assign act_edge = tick_en && act && !act_prev;

  always_ff @(posedge clk)
    if (rst)          act_prev <= 1'b0;
    else if (tick_en) act_prev <= act;

  // R8: one active edge produces exactly one count pulse
  a_r8_single_edge: assert property (@(posedge clk) disable iff (rst)
    act_edge |=> !act_edge);
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse
);
  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] last;
  logic             at_end;

  assign last   = div_ratio(sel) - 8'd1;
  assign at_end = (pcnt >= last);
  assign pulse  = advance && at_end;

  always_ff @(posedge clk)
    if (rst || clear)  pcnt <= '0;
    else if (advance)  pcnt <= at_end ? '0 : pcnt + 8'd1;

  // R1: phase never exceeds the largest ratio
  a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
    pcnt < 8'd200);
  // R6: a cleared prescaler starts from phase zero
  a_r6_clear_phase: assert property (@(posedge clk) disable iff (rst)
    clear |=> pcnt == '0);
endmodule

// File: rtl/ptmr_down_counter.sv
module ptmr_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         data_wr,
  input  logic [W-1:0] data_in,
  input  logic         stopped,
  input  logic         pulse,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic [W-1:0] tconst;
  logic [W-1:0] reload;

  assign expire = pulse && (cnt == ONE);
  assign reload = data_wr ? data_in : tconst;

  always_ff @(posedge clk)
    if (rst)          tconst <= '0;
    else if (data_wr) tconst <= data_in;

  always_ff @(posedge clk)
    if (rst)                     cnt <= '0;
    else if (data_wr && stopped) cnt <= data_in;
    else if (pulse)              cnt <= (cnt == ONE) ? reload : cnt - ONE;

  // R4: a pulse away from one decrements by exactly one
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (pulse && cnt != ONE && !(data_wr && stopped)) |=> cnt == $past(cnt) - ONE);
  // R3: the value after an expiry is the time constant
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt == tconst);
  // R6: no pulse and no load keeps the count
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!pulse && !data_wr) |=> $stable(cnt));
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import ptmr_pkg::*;
#(
  parameter int W           = 8,
  parameter bit FULL_MODES  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              aux_in,
  input  logic              aux_active_high,
  input  logic              ctl_wr,
  input  logic [MODE_W-1:0] ctl_mode,
  input  logic              ctl_out_clr,
  input  logic              data_wr,
  input  logic [W-1:0]      data_in,
  input  logic              data_rd,
  output logic [W-1:0]      data_out,
  output logic              timeout,
  output logic              tout_pin,
  output logic              irq_invert
);
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_wr;
  kind_e             kind;
  logic              act, act_edge;
  logic              psc_adv, psc_clr, psc_pulse, cnt_pulse, expire;
  logic [W-1:0]      cnt;
  logic              out_clr;

  generate
    if (FULL_MODES) begin : g_full
      assign mode_wr = ctl_mode;
    end else begin : g_delay_only
      assign mode_wr = {1'b0, ctl_mode[SEL_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk)
    if (rst)         mode_q <= '0;
    else if (ctl_wr) mode_q <= mode_wr;

  assign kind = mode_kind(mode_q);

  ptmr_aux_sync #(.STAGES(SYNC_STAGES)) u_aux (
    .clk(clk), .rst(rst), .tick_en(tick_en), .aux_in(aux_in),
    .active_high(aux_active_high), .act(act), .act_edge(act_edge));

  assign psc_clr = (kind == K_STOP) || (kind == K_EVENT);
  assign psc_adv = tick_en && ((kind == K_DELAY) || (kind == K_PULSE && act));

  ptmr_prescaler u_psc (
    .clk(clk), .rst(rst), .clear(psc_clr), .advance(psc_adv),
    .sel(mode_q[SEL_W-1:0]), .pulse(psc_pulse));

  assign cnt_pulse = (kind == K_EVENT) ? act_edge : psc_pulse;

  ptmr_down_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_in(data_in),
    .stopped(kind == K_STOP), .pulse(cnt_pulse), .cnt(cnt), .expire(expire));

  assign out_clr = ctl_wr && ctl_out_clr;

  always_ff @(posedge clk)
    if (rst) begin
      timeout    <= 1'b0;
      tout_pin   <= 1'b0;
      irq_invert <= 1'b0;
      data_out   <= '0;
    end else begin
      timeout    <= expire;
      irq_invert <= (kind == K_PULSE);
      if (out_clr)     tout_pin <= 1'b0;
      else if (expire) tout_pin <= ~tout_pin;
      if (data_rd)     data_out <= cnt;
    end

  // R3: time-out lasts a single cycle
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);
  // R9: every expiry without a clear flips the pin
  a_r9_toggle: assert property (@(posedge clk) disable iff (rst)
    (expire && !out_clr) |=> tout_pin != $past(tout_pin));
  // R9: the output-reset bit wins
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    out_clr |=> !tout_pin);
  // R2: the delay-only variant never flags inversion
  a_r2_reduced: assert property (@(posedge clk) disable iff (rst)
    !FULL_MODES |-> !irq_invert);
  // R1: a stopped channel never counts
  a_r1_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (kind == K_STOP) |-> !cnt_pulse);
endmodule

// File: tb/pscl_timer_test.sv
`timescale 1ns/1ps
module pscl_timer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 0, aux_in = 0, aux_hi = 1, ctl_wr = 0, ctl_out_clr = 0;
  logic [3:0] ctl_mode = 0;
  logic data_wr = 0, data_rd = 0;
  logic [7:0] data_in = 0;
  logic [7:0] data_out, data_out_r;
  logic timeout, tout_pin, irq_invert, timeout_r, tout_pin_r, irq_invert_r;

  int n_chk = 0, n_fail = 0, n_to = 0;
  string tag = "R9";

  always #4 clk = ~clk;

  pscl_timer uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .aux_in(aux_in), .aux_active_high(aux_hi),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_out_clr(ctl_out_clr), .data_wr(data_wr),
    .data_in(data_in), .data_rd(data_rd), .data_out(data_out), .timeout(timeout),
    .tout_pin(tout_pin), .irq_invert(irq_invert));

  pscl_timer #(.FULL_MODES(1'b0)) uut_red (
    .clk(clk), .rst(rst), .tick_en(tick_en), .aux_in(aux_in), .aux_active_high(aux_hi),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode), .ctl_out_clr(ctl_out_clr), .data_wr(data_wr),
    .data_in(data_in), .data_rd(data_rd), .data_out(data_out_r), .timeout(timeout_r),
    .tout_pin(tout_pin_r), .irq_invert(irq_invert_r));

  // reference model state
  logic [3:0] m_mode;
  logic m_s1, m_s2, m_actp, m_to, m_pin, m_inv;
  logic [7:0] m_pc, m_cnt, m_tc, m_dout;

  function automatic logic [7:0] ratio(input logic [2:0] s);
    case (s)
      3'd2: return 8'd10; 3'd3: return 8'd16; 3'd4: return 8'd50;
      3'd5: return 8'd64; 3'd6: return 8'd100; 3'd7: return 8'd200;
      default: return 8'd4;
    endcase
  endfunction

  task automatic model_step();
    logic stp, ev, pw, actv, evt, pen, pp, cp, ex;
    logic [7:0] r;
    if (rst) begin
      m_mode = 0; m_s1 = 0; m_s2 = 0; m_actp = 0; m_to = 0; m_pin = 0; m_inv = 0;
      m_pc = 0; m_cnt = 0; m_tc = 0; m_dout = 0;
      return;
    end
    stp  = (m_mode == 4'd0);
    ev   = (m_mode == 4'd8);
    pw   = m_mode[3] && (m_mode[2:0] != 0);
    actv = (m_s2 == aux_hi);
    evt  = tick_en && actv && !m_actp;
    r    = ratio(m_mode[2:0]);
    pen  = tick_en && !stp && !ev && (!pw || actv);
    pp   = pen && (m_pc >= r - 1);
    cp   = ev ? evt : pp;
    ex   = cp && (m_cnt == 8'd1);
    if (data_rd) m_dout = m_cnt;
    if (data_wr && stp) m_cnt = data_in;
    else if (cp) m_cnt = (m_cnt == 8'd1) ? (data_wr ? data_in : m_tc) : m_cnt - 8'd1;
    if (data_wr) m_tc = data_in;
    if (stp || ev) m_pc = 0;
    else if (pen) m_pc = (m_pc >= r - 1) ? 8'd0 : m_pc + 8'd1;
    if (tick_en) m_actp = actv;
    m_s2 = m_s1; m_s1 = aux_in;
    m_to = ex;
    if (ctl_wr && ctl_out_clr) m_pin = 0;
    else if (ex) m_pin = ~m_pin;
    m_inv = pw;
    if (ctl_wr) m_mode = ctl_mode;
  endtask

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // one clock: inputs are already set; compare at the following falling edge
  task automatic cyc();
    logic rd_was;
    rd_was = data_rd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({tag, "/R3"}, "timeout", timeout, m_to);
    chk({tag, "/R9"}, "tout_pin", tout_pin, m_pin);
    chk({tag, "/R10"}, "irq_invert", irq_invert, m_inv);
    if (rd_was) chk({tag, "/R11"}, "data_out", data_out, m_dout);
    if (irq_invert_r) chk("R2", "reduced irq_invert", irq_invert_r, 0);
    if (timeout) n_to++;
    ctl_wr = 0; ctl_out_clr = 0; data_wr = 0; data_rd = 0;
  endtask

  task automatic run(input int n, input bit tick);
    for (int i = 0; i < n; i++) begin tick_en = tick; cyc(); end
  endtask

  task automatic set_mode(input logic [3:0] m);
    ctl_wr = 1; ctl_mode = m; cyc();
  endtask

  task automatic wr_data(input logic [7:0] d);
    data_wr = 1; data_in = d; cyc();
  endtask

  task automatic rd_data();
    data_rd = 1; cyc();
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v1;
    int t0;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1; model_step(); rst = 0;
    @(negedge clk);
    tag = "R9";
    chk("R9", "tout_pin after reset", tout_pin, 0);
    chk("R3", "timeout after reset", timeout, 0);

    // R5 and R11: load while stopped, read back
    tag = "R5"; wr_data(8'd5); rd_data();
    chk("R5", "load while stopped", data_out, 5);
    chk("R11", "read capture", data_out, m_dout);

    // R1: delay /16 with constant 3 -> one expiry per 48 ticks
    tag = "R1"; wr_data(8'd3); set_mode(4'd3);
    t0 = n_to; run(500, 1);
    chk("R1", "expiries in 500 ticks at /16 x3", n_to - t0, 10);

    // R5: write while running only affects the next reload
    tag = "R5"; set_mode(4'd0); wr_data(8'd20); set_mode(4'd1);
    run(6, 1); wr_data(8'd2); rd_data();
    chk("R5", "running write does not touch counter", data_out < 8'd20 && data_out > 8'd2, 1);
    run(200, 1);

    // R4: constant 0 -> 256 pulses per expiry
    tag = "R4"; set_mode(4'd0); wr_data(8'd0); set_mode(4'd1);
    t0 = n_to; run(2100, 1);
    chk("R4", "expiries in 2100 ticks at /4 x256", n_to - t0, 2);

    // R6: stop holds the count
    tag = "R6"; set_mode(4'd0); rd_data(); v1 = data_out;
    run(50, 1); rd_data();
    chk("R6", "count held while stopped", data_out, v1);

    // R7: pulse-width gating, active high
    tag = "R7"; aux_hi = 1; aux_in = 0; wr_data(8'd1); set_mode(4'd9);
    t0 = n_to; run(200, 1);
    chk("R7", "no expiry while gate inactive", n_to - t0, 0);
    chk("R10", "invert flag in pulse-width", irq_invert, 1);
    aux_in = 1; run(43, 1);
    chk("R7", "expiries while gate active", n_to - t0, 10);
    aux_in = 0; run(10, 1);

    // R8: event count, six active edges, constant 2
    tag = "R8"; set_mode(4'd0); wr_data(8'd2); set_mode(4'd8); run(10, 1);
    t0 = n_to;
    for (int e = 0; e < 6; e++) begin
      aux_in = 1; run(8, 1); aux_in = 0; run(8, 1);
    end
    chk("R8", "expiries from six edges", n_to - t0, 3);

    // R9: output-reset bit forces pin low
    tag = "R9"; ctl_wr = 1; ctl_mode = 4'd8; ctl_out_clr = 1; cyc();
    chk("R9", "pin after clear", tout_pin, 0);

    // R10 back to 0 outside pulse-width mode
    tag = "R10"; set_mode(4'd1); run(2, 1);
    chk("R10", "invert flag off in delay mode", irq_invert, 0);

    // R2: reduced variant treats code 8 as stop
    tag = "R2"; set_mode(4'd8); wr_data(8'h5A); rd_data();
    chk("R2", "reduced variant stopped at code 8", data_out_r, 8'h5A);
    set_mode(4'd9); run(3, 1);
    chk("R2", "reduced variant no invert", irq_invert_r, 0);

    // random traffic against the model
    tag = "R3";
    for (int i = 0; i < 20000; i++) begin
      tick_en = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 39) == 0) aux_in = ~aux_in;
      if ($urandom_range(0, 299) == 0) aux_hi = ~aux_hi;
      if ($urandom_range(0, 199) == 0) begin
        ctl_wr = 1; ctl_mode = 4'($urandom_range(0, 15));
        ctl_out_clr = ($urandom_range(0, 3) == 0);
      end
      if ($urandom_range(0, 99) == 0) begin
        data_wr = 1; data_in = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 1)) : 8'($urandom_range(0, 12));
      end
      if ($urandom_range(0, 9) == 0) data_rd = 1;
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule